// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

This block drives a serial peripheral bus from a table of transfer descriptors held inside the block. Software fills the descriptor table through a small register port and sets a first and a last table index. It then issues a single start command. The sequencer walks the table on its own. For each descriptor it selects one of four peripheral lines, shifts a word of programmable length out and in, and stores the received word in a receive table at the same index. It then waits the requested number of serial clock periods before it moves on.

The serial engine uses mode 0: the clock idles low, the peripheral samples on the rising edge and data changes on the falling edge. Bits go out most significant first. A run either ends after the last index, which raises a completion flag and a one-cycle interrupt, or it loops from the last index back to the first until software asks it to stop. A stop request takes effect only when no word is in flight. While a run is active the pointer register and the descriptor table are locked. Any write to them is dropped and flags an error.

Top module: `qspi_seq`

## Requirements
- R1: Register map, with `reg_addr[5:4]` selecting the region. Region 0 holds control at sub-address 0 (bit0 start, bit1 stop, bit2 loop mode), pointers at sub-address 1 (first index in [3:0], last index in [11:8]) and status at sub-address 2 (last finished index in [3:0], done [8], error [9], busy [10]). Region 1 is the descriptor table and region 2 is the receive table, both indexed by `reg_addr[3:0]`. A descriptor word packs data in [15:0], select index in [17:16], bit count minus one in [21:18], gap in [29:22] and keep-select in [30]. Descriptors read back as written.
- R2: After a start, descriptors are executed in index order from the first index to the last index with no further writes. The index wraps from 15 to 0 when last < first.
- R3: Each word is sent in mode 0. The clock is low whenever no word is in flight. (bit count field + 1) bits are sent, taken from data[len-1:0] with the MSB first. Rising edges are spaced 2·HALF_DIV clock cycles apart. The same number of input bits is gathered, right-aligned and zero-extended.
- R4: `cs_n` is active low and one-hot. The asserted line is the descriptor's select index. Never more than one line is low, and all lines are high when idle.
- R5: The last rising serial edge of one word and the first rising edge of the next are exactly 3·HALF_DIV + 1 + max(1, 2·HALF_DIV·gap) clock cycles apart.
- R6: With keep-select set, the select line stays low through the gap. Without it, all lines go high for at least one cycle between words.
- R7: The received word of descriptor i lands in receive slot i, and the other slots are untouched. The status index field shows the descriptor finished most recently.
- R8: In single-pass mode, finishing the last index sets the done flag and pulses `irq` high for exactly one cycle. The next start clears done.
- R9: In loop mode, the descriptor after the last index is the first index again. The run never sets done or pulses `irq`.
- R10: A stop request takes effect only at a word boundary. No partial word appears on the bus, and all select lines are released.
- R11: While busy, writes to the pointer register or the descriptor table are ignored and set the error flag. A start command clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register/table address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational on reg_addr) |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low peripheral selects |
| irq | output | 1 | One-cycle pulse at end of a single pass |

## Verification
The bench drives a peripheral model that records every bit at the rising serial edge. It checks word length and content against its own descriptor copy at both extremes, a single bit and a full sixteen bits. A design that shifted one bit too many or too few would report the wrong word and the wrong receive slot contents. The bench measures the spacing between consecutive words for gaps of zero and non-zero. An off-by-one in the gap counter would show up as a spacing mismatch. The bench also checks that the select line is held or dropped according to the keep flag. A loop run that wraps the index through 15 to 0 is stopped mid-stream. A design that cut a word short, raised completion, or kept a select line low would fail the boundary checks. Writes during a run confirm the table and pointers are unchanged and that the error flag is set.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    localparam int DATA_W = 16;
    localparam int CSI_W  = 2;
    localparam int LEN_W  = 4;
    localparam int DLY_W  = 8;
    localparam int NUM_CS = 1 << CSI_W;

    typedef struct packed {
        logic             keep_cs;
        logic [DLY_W-1:0] gap;
        logic [LEN_W-1:0] nbits_m1;
        logic [CSI_W-1:0] cs_idx;
        logic [DATA_W-1:0] data;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_GAP} seq_state_t;

    localparam logic [1:0] REGION_CSR = 2'd0;
    localparam logic [1:0] REGION_TXQ = 2'd1;
    localparam logic [1:0] REGION_RXQ = 2'd2;
    localparam logic [3:0] CSR_CTRL   = 4'd0;
    localparam logic [3:0] CSR_PTR    = 4'd1;
    localparam logic [3:0] CSR_STAT   = 4'd2;

    function automatic logic [NUM_CS-1:0] cs_onehot(input logic [CSI_W-1:0] idx);
        logic [NUM_CS-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/qspi_shift.sv
module qspi_shift
    import qspi_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  nbits_m1,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0]  div_q;
    logic [LEN_W-1:0]  left_q;
    logic [DATA_W-1:0] sh_q;
    logic              tick;

    assign tick = (div_q == DIV_W'(HALF_DIV - 1));
    assign mosi = busy & sh_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            left_q  <= '0;
            sh_q    <= '0;
            sclk    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    // left-align the active bits so the MSB leaves first
                    sh_q    <= tx_word << (LEN_W'(DATA_W - 1) - nbits_m1);
                    left_q  <= nbits_m1;
                    rx_word <= '0;
                    div_q   <= '0;
                    sclk    <= 1'b0;
                    busy    <= 1'b1;
                end
            end else if (!tick) begin
                div_q <= div_q + 1'b1;
            end else begin
                div_q <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_word <= {rx_word[DATA_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (left_q == '0) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        left_q <= left_q - 1'b1;
                        sh_q   <= sh_q << 1;
                    end
                end
            end
        end
    end

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !sclk);
    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/qspi_store.sv
module qspi_store
    import qspi_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_we,
    input  logic [IW-1:0]     tx_waddr,
    input  entry_t            tx_wdata,
    input  logic [IW-1:0]     seq_raddr,
    output entry_t            seq_rdata,
    input  logic [IW-1:0]     host_raddr,
    output entry_t            host_rdata,
    input  logic              rx_we,
    input  logic [IW-1:0]     rx_waddr,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic [IW-1:0]     rx_raddr,
    output logic [DATA_W-1:0] rx_rdata
);
    entry_t            txq [DEPTH];
    logic [DATA_W-1:0] rxq [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    txq[i] <= '0;
                    rxq[i] <= '0;
                end else begin
                    if (tx_we && tx_waddr == IW'(i)) txq[i] <= tx_wdata;
                    if (rx_we && rx_waddr == IW'(i)) rxq[i] <= rx_wdata;
                end
            end
        end
    endgenerate

    assign seq_rdata  = txq[seq_raddr];
    assign host_rdata = txq[host_raddr];
    assign rx_rdata   = rxq[rx_raddr];
endmodule

// File: rtl/qspi_seq.sv
module qspi_seq
    import qspi_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    localparam int IW    = $clog2(DEPTH);
    localparam int CNT_W = DLY_W + $clog2(2 * HALF_DIV) + 1;

    seq_state_t        state_q;
    logic [IW-1:0]     cur_q, pstart_q, pend_q, last_q;
    logic              wrap_q, stop_q, done_q, err_q, cs_on_q, irq_q;
    logic [CNT_W-1:0]  cnt_q;

    entry_t            cur_e, host_e;
    logic [DATA_W-1:0] sh_rx, rx_rd;
    logic              sh_busy, sh_done, go;

    logic [1:0] region;
    logic [3:0] sub;
    logic running, wr_ctrl, wr_ptr, wr_tx, start_req, at_end;
    logic [IW-1:0]    nxt_idx;
    logic [CNT_W-1:0] gap_len;

    assign region    = reg_addr[5:4];
    assign sub       = reg_addr[3:0];
    assign running   = (state_q != ST_IDLE);
    assign wr_ctrl   = reg_wr && region == REGION_CSR && sub == CSR_CTRL;
    assign wr_ptr    = reg_wr && region == REGION_CSR && sub == CSR_PTR;
    assign wr_tx     = reg_wr && region == REGION_TXQ;
    assign start_req = wr_ctrl && reg_wdata[0] && !running;
    assign at_end    = (cur_q == pend_q);
    assign nxt_idx   = at_end ? pstart_q : cur_q + 1'b1;
    assign gap_len   = CNT_W'(cur_e.gap) * CNT_W'(2 * HALF_DIV);
    assign go        = (state_q == ST_SETUP) && (cnt_q == CNT_W'(HALF_DIV - 1));

    qspi_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .tx_we     (wr_tx && !running),
        .tx_waddr  (sub[IW-1:0]),
        .tx_wdata  (entry_t'(reg_wdata[ENTRY_W-1:0])),
        .seq_raddr (cur_q),
        .seq_rdata (cur_e),
        .host_raddr(sub[IW-1:0]),
        .host_rdata(host_e),
        .rx_we     (sh_done && state_q == ST_SHIFT),
        .rx_waddr  (cur_q),
        .rx_wdata  (sh_rx),
        .rx_raddr  (sub[IW-1:0]),
        .rx_rdata  (rx_rd)
    );

    qspi_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .tx_word (cur_e.data),
        .nbits_m1(cur_e.nbits_m1),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            pstart_q <= '0;
            pend_q   <= '0;
            last_q   <= '0;
            wrap_q   <= 1'b0;
            stop_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cs_on_q  <= 1'b0;
            irq_q    <= 1'b0;
            cnt_q    <= '0;
        end else begin
            irq_q <= 1'b0;
            if ((wr_ptr || wr_tx) && running) err_q <= 1'b1;
            if (wr_ptr && !running) begin
                pstart_q <= reg_wdata[IW-1:0];
                pend_q   <= reg_wdata[8 +: IW];
            end
            if (wr_ctrl && !running) wrap_q <= reg_wdata[2];
            if (wr_ctrl && reg_wdata[1] && running) stop_q <= 1'b1;

            unique case (state_q)
                ST_IDLE: if (start_req) begin
                    cur_q   <= pstart_q;
                    cnt_q   <= '0;
                    cs_on_q <= 1'b1;
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                    stop_q  <= 1'b0;
                    state_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (go) state_q <= ST_SHIFT;
                end
                ST_SHIFT: if (sh_done) begin
                    last_q  <= cur_q;
                    cnt_q   <= gap_len;
                    cs_on_q <= cur_e.keep_cs;
                    state_q <= ST_GAP;
                end
                ST_GAP: begin
                    if (cnt_q > CNT_W'(1)) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (stop_q || (at_end && !wrap_q)) begin
                        cs_on_q <= 1'b0;
                        state_q <= ST_IDLE;
                        if (at_end && !wrap_q) begin
                            done_q <= 1'b1;
                            irq_q  <= 1'b1;
                        end
                    end else begin
                        cur_q   <= nxt_idx;
                        cnt_q   <= '0;
                        cs_on_q <= 1'b1;
                        state_q <= ST_SETUP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cs_n = cs_on_q ? ~cs_onehot(cur_e.cs_idx) : '1;
    assign irq  = irq_q;

    always_comb begin
        reg_rdata = '0;
        case (region)
            REGION_CSR: case (sub)
                CSR_CTRL: reg_rdata[2] = wrap_q;
                CSR_PTR: begin
                    reg_rdata[IW-1:0] = pstart_q;
                    reg_rdata[8 +: IW] = pend_q;
                end
                CSR_STAT: begin
                    reg_rdata[IW-1:0] = last_q;
                    reg_rdata[8]  = done_q;
                    reg_rdata[9]  = err_q;
                    reg_rdata[10] = running;
                end
                default: ;
            endcase
            REGION_TXQ: reg_rdata[ENTRY_W-1:0] = host_e;
            REGION_RXQ: reg_rdata[DATA_W-1:0] = rx_rd;
            default: ;
        endcase
    end

    // R4
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) |-> ($countones(~cs_n) == 1));
    // R4
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (cs_n == '1));
    // R11
    ptr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr && running) |=> ($stable(pstart_q) && $stable(pend_q) && err_q));
    // R8
    irq_done_chk: assert property (@(posedge clk) disable iff (rst) irq |-> done_q);
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
    // R9
    wrap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && running) |=> !irq);
    // R10
    stop_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT && !sh_done) |=> (state_q == ST_SHIFT));
endmodule

// File: tb/sim_qspi_seq.sv
module sim_qspi_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;
    logic        irq;

    int checks = 0;
    int fails = 0;

    qspi_seq #(.DEPTH(16), .HALF_DIV(HALF)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // bench-side descriptor copy and expected receive slots
    int b_data[16], b_cs[16], b_len[16], b_dly[16], b_keep[16], b_rx[16];
    int m_start = 0, m_end = 0, m_wrap = 0, run_gen = 0;

    // monitor state
    int seen_gen = 0, exp_idx = 0, bits = 0, frames = 0, last_done = -1;
    int have_prev = 0, prev_keep = 0, prev_dly = 0, cs_dropped = 0, since_rise = 0;
    int tx_acc = 0, rx_acc = 0, irq_cnt = 0;
    logic prev_sclk = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int low_idx(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (!v[i]) return i;
        return -1;
    endfunction

    // reference monitor, compared every clock
    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = 1'b0;
        end else begin
            if (run_gen != seen_gen) begin
                seen_gen = run_gen; have_prev = 0; bits = 0; frames = 0;
                exp_idx = m_start; cs_dropped = 0;
            end
            since_rise++;
            if ($countones(~cs_n) > 1) chk("R4 multiple selects", $countones(~cs_n), 1);
            if (cs_n == 4'hF && sclk) chk("R3 clock while deselected", 1, 0);
            if (bits == 0 && have_prev && cs_n == 4'hF) cs_dropped = 1;
            if (sclk && !prev_sclk) begin
                if (bits == 0) begin
                    if (have_prev) begin
                        chk("R5 word spacing", since_rise,
                            3 * HALF + 1 + ((2 * HALF * prev_dly) > 1 ? 2 * HALF * prev_dly : 1));
                        chk("R6 keep-select behaviour", cs_dropped, prev_keep ? 0 : 1);
                    end
                    tx_acc = 0; rx_acc = 0;
                end else begin
                    if (since_rise != 2 * HALF) chk("R3 bit spacing", since_rise, 2 * HALF);
                end
                since_rise = 0;
                if (low_idx(cs_n) != b_cs[exp_idx]) chk("R4 select index", low_idx(cs_n), b_cs[exp_idx]);
                tx_acc = (tx_acc << 1) | int'(mosi);
                rx_acc = (rx_acc << 1) | int'(miso);
                bits++;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                miso <= lfsr[0];
                if (bits == b_len[exp_idx] + 1) begin
                    chk("R3 word content", tx_acc,
                        b_data[exp_idx] & ((1 << (b_len[exp_idx] + 1)) - 1));
                    b_rx[exp_idx] = rx_acc;
                    last_done = exp_idx;
                    frames++;
                    prev_keep = b_keep[exp_idx];
                    prev_dly = b_dly[exp_idx];
                    have_prev = 1; bits = 0; cs_dropped = 0;
                    exp_idx = (exp_idx == m_end) ? m_start : (exp_idx + 1) % 16;
                end
            end
            prev_sclk = sclk;
            if (irq) irq_cnt++;
        end
    end

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] pack(input int i);
        return {1'b0, b_keep[i][0], b_dly[i][7:0], b_len[i][3:0], b_cs[i][1:0], b_data[i][15:0]};
    endfunction

    task automatic load(input int i, input int d, input int cs, input int len, input int dly, input int keep);
        b_data[i] = d; b_cs[i] = cs; b_len[i] = len; b_dly[i] = dly; b_keep[i] = keep;
        reg_write(6'h10 + 6'(i), pack(i));
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            reg_read(6'h02, s);
            if (!s[10]) return;
        end
        chk("R2 run did not finish", 1, 0);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < 16; i++) begin
            b_data[i] = 0; b_cs[i] = 0; b_len[i] = 0; b_dly[i] = 0; b_keep[i] = 0; b_rx[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        @(negedge clk);
        chk("R4 reset selects", int'(cs_n), 'hF);
        chk("R3 reset clock", int'(sclk), 0);
        chk("R8 reset irq", int'(irq), 0);
        reg_read(6'h02, r);
        chk("R1 reset status", int'(r), 0);

        load(0, 'hA5C3, 0, 15, 1, 0);
        load(1, 'h0001, 2, 0, 0, 1);
        load(2, 'h0ABC, 2, 11, 0, 0);
        load(3, 'h005A, 3, 7, 2, 1);
        load(4, 'h1234, 1, 15, 0, 0);
        load(14, 'hBEEF, 1, 15, 0, 0);
        load(15, 'h0003, 0, 3, 1, 1);
        reg_read(6'h10, r);
        chk("R1 descriptor readback", int'(r), int'(pack(0)));

        // run A: single pass over 1..3
        m_start = 1; m_end = 3; m_wrap = 0;
        reg_write(6'h01, 32'h0000_0301);
        run_gen++;
        reg_write(6'h00, 32'h1);
        wait_idle();
        chk("R2 frames in pass", frames, 3);
        reg_read(6'h02, r);
        chk("R8 done flag", int'(r[8]), 1);
        chk("R7 last index", int'(r[3:0]), 3);
        chk("R8 irq count", irq_cnt, 1);
        for (int i = 0; i < 5; i++) begin
            reg_read(6'h20 + 6'(i), r);
            chk("R7 receive slot", int'(r), b_rx[i]);
        end

        // run B: writes while busy
        m_start = 0; m_end = 4;
        reg_write(6'h01, 32'h0000_0400);
        run_gen++;
        reg_write(6'h00, 32'h1);
        repeat (20) @(negedge clk);
        reg_write(6'h01, 32'h0000_0E07);
        reg_write(6'h12, 32'h7FFF_FFFF);
        reg_read(6'h01, r);
        chk("R11 pointers locked", int'(r), 'h400);
        reg_read(6'h12, r);
        chk("R11 descriptor locked", int'(r), int'(pack(2)));
        reg_read(6'h02, r);
        chk("R11 error flag", int'(r[9]), 1);
        wait_idle();
        chk("R2 frames full table", frames, 5);
        chk("R8 irq second pass", irq_cnt, 2);

        // run C: loop mode wrapping through 15 -> 0, then stop
        m_start = 14; m_end = 1; m_wrap = 1;
        reg_write(6'h01, 32'h0000_010E);
        run_gen++;
        reg_write(6'h00, 32'h5);
        reg_read(6'h02, r);
        chk("R11 start clears error", int'(r[9]), 0);
        chk("R8 start clears done", int'(r[8]), 0);
        for (int k = 0; k < 3000 && frames < 6; k++) @(negedge clk);
        chk("R9 loop continues past last", int'(frames >= 6), 1);
        reg_write(6'h00, 32'h2);
        wait_idle();
        chk("R10 no partial word", bits, 0);
        chk("R10 selects released", int'(cs_n), 'hF);
        chk("R9 no irq in loop", irq_cnt, 2);
        reg_read(6'h02, r);
        chk("R9 no done in loop", int'(r[8]), 0);
        chk("R7 last index after stop", int'(r[3:0]), last_done);
        for (int i = 14; i < 16; i++) begin
            reg_read(6'h20 + 6'(i), r);
            chk("R7 receive slot loop", int'(r), b_rx[i]);
        end
        report();
    end
endmodule